// File: doc/BRIEF.md
# Aging Page Replacement Selector

This block picks a replacement victim among a fixed set of page or frame entries. It does not keep a full recency order. Each entry has a single touched flag and a short history register. An access strobe carries an entry number and sets that entry's touched flag.

A periodic tick ages every entry at once. Each history value moves one place toward its least significant bit, and the touched flag drops into the top bit. The result is a recency score that costs one small shift register per entry, where exact least-recently-used ordering would need a full ordering network. When the surrounding logic asks for a victim, the block returns the index with the lowest score. Entries that the caller marks as not in use are always chosen first.

Top module: `aging_victim_sel`

## Requirements
- R1: A cycle with `acc_valid_i` high sets the touched flag of entry `acc_idx_i`. The flag stays set until the next tick.
- R2: On a cycle with `tick_i` high, every entry's history shifts right by one bit. Its touched flag enters at bit 7, the most significant bit, and the old bit 0 is discarded. Then the flag clears. Without a tick, history does not change.
- R3: An access in the same cycle as a tick belongs to the next interval. The old flag value is shifted in, and the flag is left set after the shift.
- R4: Among entries with `entry_live_i` bit = 1, the victim is the one whose 8-bit history is smallest, compared as an unsigned number.
- R5: When several live entries share the smallest history, the lowest index wins.
- R6: An entry with `entry_live_i` bit = 0 is preferred over every live entry. Among such entries, the lowest index wins.
- R7: Reset clears every history and touched flag and drops `vic_vld_o`. With all entries live, the first request after reset returns index 0.
- R8: `vic_req_i` high in a cycle gives `vic_vld_o` high for exactly the next cycle. `vic_idx_o` is then computed from the state and `entry_live_i` of the request cycle, so an access or tick in that same cycle is not seen. Without a request, `vic_vld_o` is low.
- R9: History is 8 bits wide. An entry that goes untouched for 8 or more ticks has history 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | Access strobe |
| acc_idx_i | input | IDX_W (3) | Entry number of the access |
| tick_i | input | 1 | Aging tick |
| entry_live_i | input | ENTRIES (8) | Per-entry in-use mask, 1 = live |
| vic_req_i | input | 1 | Victim request |
| vic_vld_o | output | 1 | Victim result valid, one cycle after request |
| vic_idx_o | output | IDX_W (3) | Selected victim index |

## Verification
The bench goes after several corner cases:
- Ties among equal histories. A selector that picks the last or an arbitrary tied entry would return a higher index.
- An access that coincides with a tick. A design that folds it into the current interval would put the bit in the MSB one tick too early and leave the flag clear.
- Masks with one or more dead entries. A selector that ignores the mask would return a live entry with low history.
- Eight or more idle ticks. A wider or saturating history would keep stale ones.
- Requests issued alongside accesses and ticks. A design that answers from post-edge state would report a different victim.

// File: rtl/aging_pkg.sv
package aging_pkg;
    localparam int unsigned AGE_ENTRIES_DEF = 8;
    localparam int unsigned AGE_HIST_W_DEF  = 8;
endpackage

// File: rtl/aging_entry.sv
module aging_entry #(
    parameter int unsigned HIST_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hit_i,
    input  logic              tick_i,
    output logic [HIST_W-1:0] hist_o
);
    typedef struct packed {
        logic              touched;
        logic [HIST_W-1:0] hist;
    } ent_state_t;

    ent_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d.hist    = {state_q.touched, state_q.hist[HIST_W-1:1]};
            state_d.touched = hit_i;
        end else if (hit_i) begin
            state_d.touched = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign hist_o = state_q.hist;

    assert_ref_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i |=> state_q.touched);
    assert_tick_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_i && tick_i) |=> state_q.touched);
    assert_tick_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !hit_i) |=> !state_q.touched);
    assert_age_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> state_q.hist[HIST_W-2:0] == $past(state_q.hist[HIST_W-1:1]));
    assert_hist_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(state_q.hist));
endmodule

// File: rtl/aging_argmin.sv
module aging_argmin #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned HIST_W  = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES*HIST_W-1:0] hist_i,
    input  logic [ENTRIES-1:0]        live_i,
    output logic [IDX_W-1:0]          idx_o
);
    localparam int unsigned KEY_W = HIST_W + 1;

    logic [KEY_W-1:0] best_key;
    logic [KEY_W-1:0] cand_key;

    // Dead entries score zero; live entries score above any dead one.
    always_comb begin
        best_key = '1;
        idx_o    = '0;
        cand_key = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            cand_key = live_i[i] ? {1'b1, hist_i[i*HIST_W +: HIST_W]} : '0;
            if (cand_key < best_key) begin
                best_key = cand_key;
                idx_o    = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (!$isunknown(live_i) && !$isunknown(idx_o)) begin
            assert_dead_first_R6: assert ((&live_i) || !live_i[idx_o]);
        end
    end
endmodule

// File: rtl/aging_victim_sel.sv
module aging_victim_sel
    import aging_pkg::*;
#(
    parameter int unsigned ENTRIES = AGE_ENTRIES_DEF,
    parameter int unsigned HIST_W  = AGE_HIST_W_DEF,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               acc_valid_i,
    input  logic [IDX_W-1:0]   acc_idx_i,
    input  logic               tick_i,
    input  logic [ENTRIES-1:0] entry_live_i,
    input  logic               vic_req_i,
    output logic               vic_vld_o,
    output logic [IDX_W-1:0]   vic_idx_o
);
    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } vic_state_t;

    logic [ENTRIES*HIST_W-1:0] hist_flat;
    logic [IDX_W-1:0]          pick_idx;
    vic_state_t                out_d, out_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic hit;
        assign hit = acc_valid_i && (acc_idx_i == IDX_W'(g));
        aging_entry #(.HIST_W(HIST_W)) ent_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .hit_i  (hit),
            .tick_i (tick_i),
            .hist_o (hist_flat[g*HIST_W +: HIST_W])
        );
    end

    aging_argmin #(.ENTRIES(ENTRIES), .HIST_W(HIST_W)) min_i (
        .hist_i (hist_flat),
        .live_i (entry_live_i),
        .idx_o  (pick_idx)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = vic_req_i;
        if (vic_req_i) out_d.idx = pick_idx;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign vic_vld_o = out_q.vld;
    assign vic_idx_o = out_q.idx;

    assert_vld_after_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vic_req_i |=> vic_vld_o);
    assert_no_vld_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vic_req_i |=> !vic_vld_o);
    assert_idx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vic_req_i |=> $stable(vic_idx_o));
endmodule

// File: tb/aging_victim_sel_tb_top.sv
module aging_victim_sel_tb_top;
    localparam int N = 8;
    localparam int W = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_v = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic          tick = 1'b0;
    logic [N-1:0]  live = '1;
    logic          req = 1'b0;
    logic          vld;
    logic [IW-1:0] vidx;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit [W-1:0] m_hist [N];
    bit         m_ref  [N];
    int         exp_q [$];
    string      tag_q [$];
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    aging_victim_sel dut_i (
        .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_v), .acc_idx_i(acc_idx),
        .tick_i(tick), .entry_live_i(live), .vic_req_i(req),
        .vic_vld_o(vld), .vic_idx_o(vidx)
    );

    function automatic int model_victim(input logic [N-1:0] lv);
        int best = 0;
        int best_h = 1 << W;
        for (int i = 0; i < N; i++) if (!lv[i]) return i;
        for (int i = 0; i < N; i++) begin
            if (int'(m_hist[i]) < best_h) begin
                best_h = int'(m_hist[i]);
                best = i;
            end
        end
        return best;
    endfunction

    // Monitor half: compare what the previous cycle's request should produce.
    task automatic monitor_check();
        checks++;
        if (exp_q.size() > 0) begin
            int e = exp_q.pop_front();
            string t = tag_q.pop_front();
            if (!vld || int'(vidx) != e) begin
                fails++;
                $display("FAIL %s: vld=%0b idx=%0d expected vld=1 idx=%0d", t, vld, vidx, e);
            end
        end else if (vld) begin
            fails++;
            $display("FAIL R8: vld=%0b idx=%0d expected vld=0", vld, vidx);
        end
    endtask

    task automatic step(input bit a, input int idx, input bit t, input bit r,
                        input logic [N-1:0] lv, input string tag);
        @(negedge clk);
        monitor_check();
        acc_v = a; acc_idx = IW'(idx); tick = t; req = r; live = lv;
        if (r) begin
            exp_q.push_back(model_victim(lv));
            tag_q.push_back(tag);
        end
        if (t) begin
            for (int i = 0; i < N; i++) begin
                m_hist[i] = {m_ref[i], m_hist[i][W-1:1]};
                m_ref[i] = 1'b0;
            end
        end
        if (a) m_ref[idx] = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, '1, "R8");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_hist[i] = '0; m_ref[i] = 1'b0; end
        repeat (3) @(negedge clk);
        checks++;
        if (vld !== 1'b0) begin
            fails++;
            $display("FAIL R7: vld=%0b expected 0 in reset", vld);
        end
        rst_n = 1'b1;
        // R7: first request after reset returns 0
        step(0, 0, 0, 1, '1, "R7");
        idle(1);
        // R5: tie among untouched entries
        step(1, 3, 0, 0, '1, "R1");
        step(1, 5, 0, 0, '1, "R1");
        step(0, 0, 1, 0, '1, "R2");
        step(0, 0, 0, 1, '1, "R5");
        // R4: only entry 6 untouched
        for (int i = 0; i < N; i++) if (i != 6) step(1, i, 0, 0, '1, "R1");
        step(0, 0, 1, 0, '1, "R2");
        step(0, 0, 0, 1, '1, "R4");
        // R2 aging ordering
        step(1, 6, 0, 0, '1, "R1");
        step(0, 0, 1, 0, '1, "R2");
        step(0, 0, 0, 1, '1, "R2");
        // R3: access coinciding with tick
        step(1, 0, 0, 0, '1, "R3");
        step(1, 0, 1, 0, '1, "R3");
        step(0, 0, 1, 0, '1, "R3");
        step(0, 0, 0, 1, '1, "R3");
        // R6: dead entries first
        step(0, 0, 0, 1, 8'hEF, "R6");
        step(0, 0, 0, 1, 8'h7B, "R6");
        step(0, 0, 0, 1, 8'h00, "R6");
        // R8: request alongside access and tick sees pre-edge state
        step(1, 2, 1, 1, '1, "R8");
        step(1, 7, 0, 1, '1, "R8");
        idle(2);
        // R9: eight idle ticks flush history
        for (int k = 0; k < 8; k++) step(0, 0, 1, 0, '1, "R9");
        step(1, 4, 0, 1, '1, "R9");
        step(0, 0, 1, 0, '1, "R9");
        for (int k = 0; k < 8; k++) step(0, 0, 1, 0, '1, "R9");
        step(0, 0, 0, 1, '1, "R9");
        // Mixed traffic
        for (int k = 0; k < 400; k++) begin
            bit a, t, r;
            logic [N-1:0] lv;
            seed = seed * 32'd1103515245 + 32'd12345;
            a = seed[16];
            t = (seed[20:18] == 3'd0);
            r = seed[22];
            lv = (seed[25:24] == 2'd0) ? N'(seed[31:24] | 8'h81) : '1;
            step(a, int'(seed[29:27]), t, r, lv, "R4");
        end
        idle(3);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule